// File: doc/BRIEF.md
# SD SPI Command Transaction Engine

This block runs one complete SD-card command exchange in SPI mode over a byte-wide exchange port. A start strobe latches a 6-bit command index, a 32-bit argument and a keep-selected flag. The engine then pulls chip select low and sends one lead filler byte. It follows with the six-byte command frame and then polls with 0xFF filler bytes until the card returns a status byte whose bit 7 is clear. If no such byte arrives within a fixed poll budget, the exchange ends with a timeout.

Each byte exchange uses a request/acknowledge handshake with the bit-level shifter. The engine raises a request with the byte to transmit and holds it until the shifter acknowledges. The acknowledge arrives together with the byte received in that slot. When the command index is 58, the four bytes after the status byte are captured most significant first. In the ordinary mode, chip select is released after the response and one extra filler byte is clocked. In keep-selected mode, chip select stays low so that a data block phase can follow.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first frame byte is the command index in bits 5:0 with bits 7:6 equal to 01 (0x40 | index).
- R2: Frame bytes two to five carry the argument, most significant byte first.
- R3: The sixth frame byte is 0x87 when the index is 8 and the argument is 0x000001AA, and 0x95 for every other command.
- R4: The first byte exchanged after a start is 0xFF with chip select already low. Chip select then stays low without a gap through the frame, the polling and any trailing capture.
- R5: While polling, the engine transmits 0xFF. The status output r1_o takes the first received byte whose bit 7 is 0, and poll bytes with bit 7 set (for example 0x80 and 0xFF) are skipped.
- R6: If POLL_LIMIT (default 5000) poll bytes pass without a valid byte, the engine ends with timeout_o=1 and r1_o=0xFF. Chip select is released even in keep-selected mode.
- R7: In ordinary mode, and on every timeout, chip select goes high after the last received byte. Exactly one more 0xFF byte is then exchanged with chip select high before done.
- R8: With hold_cs_i=1 at start and a valid response, chip select stays low after the status byte and no trailing filler byte is sent.
- R9: For command index 58, the four bytes after the status byte are exchanged with chip select low and presented on trail_o, the first received byte in bits 31:24.
- R10: A start strobe while busy_o is high is ignored and does not change the frame being sent. done_o is high for exactly one clock per transaction.
- R11: After reset, cs_no=1, xfer_req_o=0, busy_o=0, done_o=0 and timeout_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| hold_cs_i | input | 1 | Keep chip select low after a valid response |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |
| timeout_o | output | 1 | Last transaction ended without a response |
| r1_o | output | 8 | Status byte of the last transaction |
| trail_o | output | 32 | Four trailing bytes captured for index 58 |
| cs_no | output | 1 | Card chip select, active low |
| xfer_req_o | output | 1 | Byte exchange request, held until acknowledged |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_ack_i | input | 1 | Byte exchange complete |
| xfer_rx_i | input | 8 | Byte received, valid with xfer_ack_i |

## Verification
On every cycle, the assertions check these properties:
- chip select is low in every active phase and high in the trailing filler phase;
- the first frame byte carries the 01 prefix, and every non-frame request transmits 0xFF;
- a pending request holds its byte until acknowledged;
- done is a single-cycle pulse;
- a start during a transaction leaves the latched command unchanged;
- a timeout reports 0xFF with chip select released;
- the poll counter stays under its limit.

Only the bench scenarios can show the byte order of the frame and the CRC choice on the 0x1AA boundary. The same holds for skipping bit-7-set poll bytes, the exact byte totals that prove the single filler byte or its absence, the trailing capture order, and the full 5000-byte timeout.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CMD,
    ST_POLL,
    ST_TRAIL,
    ST_FILL
  } eng_state_e;

  localparam logic [7:0]  FILL_BYTE   = 8'hFF;
  localparam logic [7:0]  CRC_PLAIN   = 8'h95;
  localparam logic [7:0]  CRC_IFCOND  = 8'h87;
  localparam logic [1:0]  CMD_PREFIX  = 2'b01;
  localparam logic [5:0]  IFCOND_IDX  = 6'd8;
  localparam logic [31:0] IFCOND_ARG  = 32'h0000_01AA;
  localparam logic [5:0]  OCR_IDX     = 6'd58;
  localparam int unsigned FRAME_LEN   = 6;
  localparam int unsigned TRAIL_LEN   = 4;
endpackage

// File: rtl/sd_frame_gen.sv
module sd_frame_gen
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_BYTES = 4
) (
  input  logic [5:0]             cmd_i,
  input  logic [8*ARG_BYTES-1:0] arg_i,
  input  logic [2:0]             sel_i,
  output logic [7:0]             byte_o
);
  logic [7:0] arg_bytes [ARG_BYTES];
  logic [7:0] crc_byte;

  // argument bytes in transmit order, most significant first
  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign arg_bytes[g] = arg_i[8*(ARG_BYTES-g)-1 -: 8];
  end

  assign crc_byte = (cmd_i == IFCOND_IDX && arg_i == IFCOND_ARG) ? CRC_IFCOND : CRC_PLAIN;

  always_comb begin
    byte_o = FILL_BYTE;
    if (sel_i == 3'd0)
      byte_o = {CMD_PREFIX, cmd_i};
    else if (int'(sel_i) <= ARG_BYTES)
      byte_o = arg_bytes[int'(sel_i) - 1];
    else if (int'(sel_i) == ARG_BYTES + 1)
      byte_o = crc_byte;
  end
endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  // current poll slot is the last one allowed
  assign expired_o = (cnt_q == CW'(POLL_LIMIT - 1));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_LIMIT));
endmodule

// File: rtl/sd_trail_shift.sv
module sd_trail_shift #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                shift_i,
  input  logic [7:0]          din_i,
  output logic [8*NBYTES-1:0] dout_o
);
  logic [8*NBYTES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (clr_i)    sh_q <= '0;
    else if (shift_i)  sh_q <= {sh_q[8*NBYTES-9:0], din_i};
  end

  assign dout_o = sh_q;
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        hold_cs_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [7:0]  r1_o,
  output logic [31:0] trail_o,
  output logic        cs_no,
  output logic        xfer_req_o,
  output logic [7:0]  xfer_tx_o,
  input  logic        xfer_ack_i,
  input  logic [7:0]  xfer_rx_i
);
  localparam logic [2:0] FRAME_LAST = 3'(FRAME_LEN - 1);
  localparam logic [2:0] TRAIL_LAST = 3'(TRAIL_LEN - 1);

  eng_state_e  state_q;
  logic [5:0]  cmd_q;
  logic [31:0] arg_q;
  logic        keep_q;
  logic [2:0]  idx_q;
  logic        req_q;
  logic [7:0]  tx_q;
  logic        cs_q;
  logic        done_q;
  logic        tout_q;
  logic [7:0]  r1_q;

  logic [7:0]  frame_byte;
  logic [7:0]  next_tx;
  logic        start_acc;
  logic        ack_fire;
  logic        poll_expired;
  logic        poll_step;
  logic        trail_step;

  assign start_acc  = (state_q == ST_IDLE) && start_i;
  assign ack_fire   = req_q && xfer_ack_i;
  assign poll_step  = ack_fire && (state_q == ST_POLL) && xfer_rx_i[7] && !poll_expired;
  assign trail_step = ack_fire && (state_q == ST_TRAIL);
  assign next_tx    = (state_q == ST_CMD) ? frame_byte : FILL_BYTE;

  sd_frame_gen #(.ARG_BYTES(4)) u_frame (
    .cmd_i  (cmd_q),
    .arg_i  (arg_q),
    .sel_i  (idx_q),
    .byte_o (frame_byte)
  );

  sd_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_acc),
    .step_i    (poll_step),
    .expired_o (poll_expired)
  );

  sd_trail_shift #(.NBYTES(TRAIL_LEN)) u_trail (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_acc),
    .shift_i (trail_step),
    .din_i   (xfer_rx_i),
    .dout_o  (trail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      arg_q   <= '0;
      keep_q  <= 1'b0;
      idx_q   <= '0;
      req_q   <= 1'b0;
      tx_q    <= FILL_BYTE;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      r1_q    <= FILL_BYTE;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          cmd_q   <= cmd_idx_i;
          arg_q   <= cmd_arg_i;
          keep_q  <= hold_cs_i;
          idx_q   <= '0;
          cs_q    <= 1'b0;
          tout_q  <= 1'b0;
          r1_q    <= FILL_BYTE;
          state_q <= ST_LEAD;
        end
      end else if (!req_q) begin
        req_q <= 1'b1;
        tx_q  <= next_tx;
      end else if (xfer_ack_i) begin
        req_q <= 1'b0;
        unique case (state_q)
          ST_LEAD: begin
            idx_q   <= '0;
            state_q <= ST_CMD;
          end
          ST_CMD: begin
            if (idx_q == FRAME_LAST) begin
              idx_q   <= '0;
              state_q <= ST_POLL;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_POLL: begin
            if (!xfer_rx_i[7]) begin
              r1_q <= xfer_rx_i;
              if (cmd_q == OCR_IDX) begin
                idx_q   <= '0;
                state_q <= ST_TRAIL;
              end else if (keep_q) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                cs_q    <= 1'b1;
                state_q <= ST_FILL;
              end
            end else if (poll_expired) begin
              tout_q  <= 1'b1;
              cs_q    <= 1'b1;
              state_q <= ST_FILL;
            end
          end
          ST_TRAIL: begin
            if (idx_q == TRAIL_LAST) begin
              if (keep_q) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                cs_q    <= 1'b1;
                state_q <= ST_FILL;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_FILL: begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = tout_q;
  assign r1_o       = r1_q;
  assign cs_no      = cs_q;
  assign xfer_req_o = req_q;
  assign xfer_tx_o  = tx_q;

  p_cs_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_LEAD, ST_CMD, ST_POLL, ST_TRAIL}) |-> !cs_no);

  p_frame_prefix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && state_q == ST_CMD && idx_q == 3'd0) |-> (xfer_tx_o[7:6] == CMD_PREFIX));

  p_filler_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && state_q != ST_CMD) |-> (xfer_tx_o == FILL_BYTE));

  p_fill_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |-> cs_no);

  p_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_tx_o)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cmd_q) && $stable(arg_q)));

  p_timeout_report_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (r1_o == FILL_BYTE && cs_no));
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  typedef struct packed {
    logic [5:0]  cmd;
    logic [31:0] arg;
    logic        keep;
    logic [7:0]  dly;
    logic [7:0]  r1;
    logic [31:0] trail;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  32'h0000_0000, 1'b0, 8'd1, 8'h01, 32'h0},
    '{6'd8,  32'h0000_01AA, 1'b0, 8'd0, 8'h01, 32'h0},
    '{6'd8,  32'h0000_01AB, 1'b0, 8'd2, 8'h05, 32'h0},
    '{6'd58, 32'h0000_0000, 1'b0, 8'd3, 8'h00, 32'hC0FF_8000},
    '{6'd17, 32'h1234_5678, 1'b1, 8'd0, 8'h00, 32'h0},
    '{6'd58, 32'h0000_0000, 1'b1, 8'd1, 8'h01, 32'h80FF_8000},
    '{6'd41, 32'h4000_0000, 1'b0, 8'd7, 8'h04, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd = '0;
  logic [31:0] arg = '0;
  logic        hold = 1'b0;
  logic        busy, done, tout, cs_n, req, ack;
  logic [7:0]  r1, tx, rx;
  logic [31:0] trail;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // slave model state
  int          dly = 0;
  logic [7:0]  r1v = '0;
  logic [31:0] trailv = '0;
  int          nb = 0;
  int          cs_high_cnt = 0;
  int          lat = 0;
  logic [7:0]  log_tx [16];
  logic        log_cs [16];
  logic        last_cs = 1'b1;
  int          done_cnt = 0;
  int          done_double = 0;
  logic        done_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_idx_i(cmd), .cmd_arg_i(arg),
    .hold_cs_i(hold), .busy_o(busy), .done_o(done), .timeout_o(tout), .r1_o(r1),
    .trail_o(trail), .cs_no(cs_n), .xfer_req_o(req), .xfer_tx_o(tx),
    .xfer_ack_i(ack), .xfer_rx_i(rx)
  );

  function automatic logic [7:0] rx_for(int n);
    int k;
    if (n < 7) return 8'hFF;
    k = n - 7;
    if (k < dly) return (k % 2 == 1) ? 8'h80 : 8'hFF;
    if (k == dly) return r1v;
    if (k <= dly + 4) return trailv[31 - 8*(k - dly - 1) -: 8];
    return 8'hFF;
  endfunction

  // byte-exchange responder, acknowledges two cycles after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; rx <= 8'hFF; lat <= 0;
    end else if (start && !busy) begin
      nb <= 0; cs_high_cnt <= 0; lat <= 0;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (req) begin
      if (lat == 1) begin
        ack <= 1'b1;
        rx  <= rx_for(nb);
        if (nb < 16) begin
          log_tx[nb] <= tx;
          log_cs[nb] <= cs_n;
        end
        if (cs_n) cs_high_cnt <= cs_high_cnt + 1;
        last_cs <= cs_n;
        nb  <= nb + 1;
        lat <= 0;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (done && done_prev) done_double <= done_double + 1;
    done_prev <= done;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic launch(input logic [5:0] c, input logic [31:0] a, input logic k,
                        input int d, input logic [7:0] rv, input logic [31:0] tv);
    @(negedge clk);
    cmd = c; arg = a; hold = k; dly = d; r1v = rv; trailv = tv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_frame(input logic [5:0] c, input logic [31:0] a);
    logic [7:0] crc;
    crc = (c == 6'd8 && a == 32'h0000_01AA) ? 8'h87 : 8'h95;
    chk(log_tx[0] == 8'hFF && log_cs[0] == 1'b0, "R4 lead byte", {log_tx[0], 7'd0, log_cs[0]}, 16'hFF00);
    chk(log_tx[1] == {2'b01, c}, "R1 first frame byte", log_tx[1], {2'b01, c});
    chk({log_tx[2], log_tx[3], log_tx[4], log_tx[5]} == a, "R2 argument bytes",
        {log_tx[2], log_tx[3], log_tx[4], log_tx[5]}, a);
    chk(log_tx[6] == crc, "R3 crc byte", log_tx[6], crc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_nb;
    int dc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1 && req == 1'b0 && busy == 1'b0 && done == 1'b0 && tout == 1'b0,
        "R11 reset state", {cs_n, req, busy, done, tout}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R11 idle after reset", {cs_n, busy}, 2'b10);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      dc = done_cnt;
      launch(v.cmd, v.arg, v.keep, int'(v.dly), v.r1, v.trail);
      wait_done();
      check_frame(v.cmd, v.arg);
      chk(r1 == v.r1 && tout == 1'b0, "R5 status byte", {tout, r1}, {1'b0, v.r1});
      exp_nb = 7 + int'(v.dly) + 1 + ((v.cmd == 6'd58) ? 4 : 0) + (v.keep ? 0 : 1);
      chk(nb == exp_nb, v.keep ? "R8 byte count" : "R7 byte count", nb, exp_nb);
      if (v.keep) begin
        chk(cs_n == 1'b0 && cs_high_cnt == 0, "R8 cs held low", {cs_n, 8'(cs_high_cnt)}, 0);
      end else begin
        chk(cs_n == 1'b1 && cs_high_cnt == 1 && last_cs == 1'b1, "R7 single released filler",
            {cs_n, last_cs, 8'(cs_high_cnt)}, {2'b11, 8'd1});
      end
      if (v.cmd == 6'd58)
        chk(trail == v.trail, "R9 trailing capture", trail, v.trail);
      @(negedge clk);
      chk(done_cnt == dc + 1 && done == 1'b0, "R10 done single pulse", done_cnt - dc, 1);
    end

    // R10: start while busy is ignored
    dc = done_cnt;
    launch(6'd17, 32'h0000_AA55, 1'b0, 5, 8'h00, 32'h0);
    repeat (10) @(negedge clk);
    cmd = 6'd24; arg = 32'hFFFF_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(log_tx[1] == 8'h51 && {log_tx[2], log_tx[3], log_tx[4], log_tx[5]} == 32'h0000_AA55,
        "R10 frame unchanged by busy start", {log_tx[1], log_tx[2], log_tx[3], log_tx[4], log_tx[5]},
        {8'h51, 32'h0000_AA55});
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && done_cnt == dc + 1, "R10 no second transaction", {busy, 8'(done_cnt - dc)}, 9'd1);

    // R6: timeout after the full poll budget, releases cs even with hold requested
    launch(6'd1, 32'h0, 1'b1, 1000000, 8'h00, 32'h0);
    wait_done();
    chk(tout == 1'b1 && r1 == 8'hFF, "R6 timeout flag and status", {tout, r1}, 9'h1FF);
    chk(nb == 7 + 5000 + 1, "R6 poll budget byte count", nb, 5008);
    chk(cs_n == 1'b1 && cs_high_cnt == 1, "R7 filler after timeout", {cs_n, 8'(cs_high_cnt)}, {1'b1, 8'd1});

    // normal run after a timeout clears the flag
    launch(6'd16, 32'h0000_0200, 1'b0, 0, 8'h00, 32'h0);
    wait_done();
    chk(tout == 1'b0 && r1 == 8'h00, "R5 recovery after timeout", {tout, r1}, 9'h000);

    chk(done_double == 0, "R10 done never two cycles", done_double, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule